// File: doc/BRIEF.md
# Sequenced Pad Pull Configuration Unit

This unit keeps the pull-resistor setting of every pad in a group of up to 54 pins. Software never writes a pin's pull setting directly. It first loads a shared 2-bit pull code, then sets bits in a per-bank selection mask (one mask word for every 32 pins). After the selection has been held steady for a programmable number of setup cycles, each selected pin captures the shared code into its own 2-bit state register. Software then clears the mask and the code. Pins that are not selected keep whatever they held before.

The captured states leave the block as one flat vector that feeds the pad logic. A separate index port returns the captured state of any single pin. A simple 32-bit word-addressed write/read port reaches the code, setup-count and mask registers. The word addresses are: 0 for the pull code, 1 for the setup count, and 4 plus the bank number for each bank's mask.

Top module: `pad_pull_sequencer`

## Requirements
- R1: After reset every pin state is off (0), the code register and all mask registers read 0, and the setup-count register reads SETUP_DEFAULT (4).
- R2: Reads return only implemented bits. The code register returns bits 1:0 of the last write, the setup register returns bits 7:0, and mask bits for pin numbers at or above NUM_PINS (bank 1 bits 31:22) always read 0.
- R3: A pin whose mask bit is set captures the code on the clock edge SETUP+1 edges after the later of the code write edge and its bank's mask write edge. Its state does not change before that edge.
- R4: A pin whose mask bit is 0 keeps its state whatever value the code register takes.
- R5: Codes 0, 1 and 2 are captured as off, pull-down and pull-up. Code 3 is reserved and is captured as off (0).
- R6: A code write restarts the setup count of every bank, so selected pins wait a full setup window after it.
- R7: The release sequence (masks cleared, then code cleared) leaves all captured states unchanged.
- R8: The read-back port returns, one cycle after the index is presented, the state of that pin. An index at or above NUM_PINS returns 0.
- R9: The setup count is programmable. With a setup count of 0, a selected pin captures on the edge that follows the mask write.
- R10: A mask write to one bank does not restart the setup count of any other bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register word address for the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | 3 | Register word address for the read |
| rd_data | output | 32 | Registered read data, valid one cycle after rd_addr |
| rb_pin | input | 6 | Pin index for the state read-back |
| rb_pull | output | 2 | Registered captured state of pin rb_pin |
| pull_state | output | 108 | Captured 2-bit state of every pin; pin i is in bits 2i+1:2i |

## Verification
The bench times every capture to the exact edge and checks the state one edge earlier too. A design that counts from the first write instead of the last would capture too early. So would one that ignores a code rewrite during the window, or lets one bank's mask write restart another bank. Other tests load reserved code 3 over an existing pull-up, expecting off rather than 3. They change the code while no pin is selected, expecting no pad to move. They use a zero setup count, expecting capture on the next edge. The bench also reads the unimplemented mask bits and a read-back index past the last pin, which must return zero rather than wrap onto a real pin.

// File: rtl/pullseq_pkg.sv
package pullseq_pkg;

  localparam int CODE_W = 2;

  typedef enum logic [CODE_W-1:0] {
    PULL_OFF  = 2'd0,
    PULL_DOWN = 2'd1,
    PULL_UP   = 2'd2,
    PULL_RSVD = 2'd3
  } pull_e;

  // word addresses of the register port
  localparam int ADDR_CODE      = 0;
  localparam int ADDR_SETUP     = 1;
  localparam int ADDR_MASK_BASE = 4;

  // reserved code folds to off when captured
  function automatic logic [CODE_W-1:0] fold_code(input logic [CODE_W-1:0] c);
    return (pull_e'(c) == PULL_RSVD) ? PULL_OFF : c;
  endfunction

endpackage

// File: rtl/pullseq_regs.sv
module pullseq_regs
  import pullseq_pkg::*;
#(
  parameter int NUM_PINS      = 54,
  parameter int BANK_W        = 32,
  parameter int NUM_BANKS     = 2,
  parameter int SETUP_W       = 8,
  parameter int SETUP_DEFAULT = 4,
  parameter int ADDR_W        = 3,
  parameter int DATA_W        = 32
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_en,
  input  logic [ADDR_W-1:0]           wr_addr,
  input  logic [DATA_W-1:0]           wr_data,
  input  logic [ADDR_W-1:0]           rd_addr,
  output logic [DATA_W-1:0]           rd_data,
  output logic [CODE_W-1:0]           code_q,
  output logic [SETUP_W-1:0]          setup_q,
  output logic [NUM_BANKS*BANK_W-1:0] mask_q,
  output logic                        code_wr,
  output logic                        setup_wr,
  output logic [NUM_BANKS-1:0]        mask_wr
);

  localparam int MASK_W = NUM_BANKS * BANK_W;

  function automatic logic [MASK_W-1:0] impl_bits();
    logic [MASK_W-1:0] r;
    for (int i = 0; i < MASK_W; i++) r[i] = (i < NUM_PINS);
    return r;
  endfunction

  localparam logic [MASK_W-1:0] IMPL_MASK = impl_bits();

  // write strobes
  always_comb begin
    code_wr  = wr_en && (int'(wr_addr) == ADDR_CODE);
    setup_wr = wr_en && (int'(wr_addr) == ADDR_SETUP);
    for (int b = 0; b < NUM_BANKS; b++)
      mask_wr[b] = wr_en && (int'(wr_addr) == ADDR_MASK_BASE + b);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q  <= '0;
      setup_q <= SETUP_W'(SETUP_DEFAULT);
      mask_q  <= '0;
    end else begin
      if (code_wr)  code_q  <= wr_data[CODE_W-1:0];
      if (setup_wr) setup_q <= wr_data[SETUP_W-1:0];
      for (int b = 0; b < NUM_BANKS; b++)
        if (mask_wr[b])
          mask_q[b*BANK_W +: BANK_W] <= wr_data[BANK_W-1:0] & IMPL_MASK[b*BANK_W +: BANK_W];
    end
  end

  // registered read mux
  logic [DATA_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (int'(rd_addr) == ADDR_CODE)  rd_mux[CODE_W-1:0]  = code_q;
    if (int'(rd_addr) == ADDR_SETUP) rd_mux[SETUP_W-1:0] = setup_q;
    for (int b = 0; b < NUM_BANKS; b++)
      if (int'(rd_addr) == ADDR_MASK_BASE + b)
        rd_mux[BANK_W-1:0] = mask_q[b*BANK_W +: BANK_W];
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_mux;
  end

  // R2: no select bit may exist for a pin that is not built
  assert_unimpl_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (mask_q & ~IMPL_MASK) == '0);

endmodule

// File: rtl/pullseq_bank_timer.sv
module pullseq_bank_timer #(
  parameter int SETUP_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               restart,
  input  logic [SETUP_W-1:0] setup,
  output logic               armed
);

  logic [SETUP_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || restart)    cnt <= '0;
    else if (cnt < setup)  cnt <= cnt + 1'b1;
  end

  assign armed = (cnt == setup);

  // R6: a restart always opens a fresh window unless the window is empty
  assert_restart_window_R6: assert property (@(posedge clk) disable iff (rst)
    restart |=> (!armed || setup == '0));

endmodule

// File: rtl/pullseq_pin_cell.sv
module pullseq_pin_cell
  import pullseq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              sel,
  input  logic              armed,
  input  logic [CODE_W-1:0] code,
  output logic [CODE_W-1:0] state
);

  always_ff @(posedge clk) begin
    if (rst)                state <= PULL_OFF;
    else if (sel && armed)  state <= fold_code(code);
  end

  // R4: an unselected pin holds
  assert_hold_unselected_R4: assert property (@(posedge clk) disable iff (rst)
    !sel |=> $stable(state));

  // R5: the reserved code never reaches a pad
  assert_no_reserved_R5: assert property (@(posedge clk) disable iff (rst)
    state != PULL_RSVD);

endmodule

// File: rtl/pullseq_readback.sv
module pullseq_readback
  import pullseq_pkg::*;
#(
  parameter int NUM_PINS = 54,
  parameter int IDX_W    = 6
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [IDX_W-1:0]           pin_idx,
  input  logic [CODE_W*NUM_PINS-1:0] states,
  output logic [CODE_W-1:0]          rb_pull
);

  logic [CODE_W-1:0] pick;
  always_comb begin
    pick = '0;
    for (int i = 0; i < NUM_PINS; i++)
      if (int'(pin_idx) == i) pick = states[CODE_W*i +: CODE_W];
  end

  always_ff @(posedge clk) begin
    if (rst) rb_pull <= '0;
    else     rb_pull <= pick;
  end

  // R8: an index past the last pin returns zero
  assert_rb_range_R8: assert property (@(posedge clk) disable iff (rst)
    (int'(pin_idx) >= NUM_PINS) |=> (rb_pull == '0));

endmodule

// File: rtl/pad_pull_sequencer.sv
module pad_pull_sequencer
  import pullseq_pkg::*;
#(
  parameter int NUM_PINS      = 54,
  parameter int BANK_W        = 32,
  parameter int SETUP_W       = 8,
  parameter int SETUP_DEFAULT = 4,
  parameter int ADDR_W        = 3,
  parameter int DATA_W        = 32
) (
  input  logic                                      clk,
  input  logic                                      rst,
  input  logic                                      wr_en,
  input  logic [ADDR_W-1:0]                         wr_addr,
  input  logic [DATA_W-1:0]                         wr_data,
  input  logic [ADDR_W-1:0]                         rd_addr,
  output logic [DATA_W-1:0]                         rd_data,
  input  logic [$clog2(((NUM_PINS+BANK_W-1)/BANK_W)*BANK_W)-1:0] rb_pin,
  output logic [1:0]                                rb_pull,
  output logic [2*NUM_PINS-1:0]                     pull_state
);

  localparam int NUM_BANKS = (NUM_PINS + BANK_W - 1) / BANK_W;
  localparam int MASK_W    = NUM_BANKS * BANK_W;
  localparam int IDX_W     = $clog2(MASK_W);

  logic [CODE_W-1:0]    code_q;
  logic [SETUP_W-1:0]   setup_q;
  logic [MASK_W-1:0]    mask_q;
  logic                 code_wr;
  logic                 setup_wr;
  logic [NUM_BANKS-1:0] mask_wr;
  logic [NUM_BANKS-1:0] armed;

  pullseq_regs #(
    .NUM_PINS(NUM_PINS), .BANK_W(BANK_W), .NUM_BANKS(NUM_BANKS),
    .SETUP_W(SETUP_W), .SETUP_DEFAULT(SETUP_DEFAULT),
    .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) regs_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .code_q(code_q), .setup_q(setup_q),
    .mask_q(mask_q), .code_wr(code_wr), .setup_wr(setup_wr), .mask_wr(mask_wr)
  );

  // one setup counter per bank; code or setup writes restart all of them
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    pullseq_bank_timer #(.SETUP_W(SETUP_W)) timer_i (
      .clk(clk), .rst(rst),
      .restart(code_wr | setup_wr | mask_wr[b]),
      .setup(setup_q),
      .armed(armed[b])
    );
  end

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    pullseq_pin_cell cell_i (
      .clk(clk), .rst(rst),
      .sel(mask_q[i]),
      .armed(armed[i / BANK_W]),
      .code(code_q),
      .state(pull_state[CODE_W*i +: CODE_W])
    );

    // R3: a pad only moves after its bank finished a full setup window
    assert_no_early_capture_R3: assert property (@(posedge clk) disable iff (rst)
      !$stable(pull_state[CODE_W*i +: CODE_W]) |-> ($past(armed[i / BANK_W]) && $past(mask_q[i])));
  end

  pullseq_readback #(.NUM_PINS(NUM_PINS), .IDX_W(IDX_W)) rb_i (
    .clk(clk), .rst(rst), .pin_idx(rb_pin), .states(pull_state), .rb_pull(rb_pull)
  );

endmodule

// File: tb/pad_pull_sequencer_tb_top.sv
module pad_pull_sequencer_tb_top;

  localparam int NP = 54;
  localparam int S  = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         wr_en = 1'b0;
  logic [2:0]   wr_addr = '0;
  logic [31:0]  wr_data = '0;
  logic [2:0]   rd_addr = '0;
  logic [31:0]  rd_data;
  logic [5:0]   rb_pin = '0;
  logic [1:0]   rb_pull;
  logic [2*NP-1:0] pull_state;

  logic [2*NP-1:0] exp_state = '0;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pad_pull_sequencer dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .rb_pin(rb_pin), .rb_pull(rb_pull),
    .pull_state(pull_state)
  );

  task automatic chk(string req, logic [127:0] act, logic [127:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic wr(int a, logic [31:0] d);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(int a, output logic [31:0] v);
    rd_addr = 3'(a);
    @(negedge clk);
    v = rd_data;
  endtask

  function automatic void set_exp(int pin, logic [1:0] v);
    exp_state[2*pin +: 2] = v;
  endfunction

  // called right after the last write: old value through edge W+S, new at W+S+1
  task automatic latch_timing(string req, logic [2*NP-1:0] old_state);
    repeat (S) @(negedge clk);
    chk({req, " before window end"}, 128'(pull_state), 128'(old_state));
    @(negedge clk);
    chk({req, " at window end"}, 128'(pull_state), 128'(exp_state));
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 states off", 128'(pull_state), 128'(0));
    rd(0, v); chk("R1 code", 128'(v), 128'(0));
    rd(4, v); chk("R1 mask0", 128'(v), 128'(0));
    rd(5, v); chk("R1 mask1", 128'(v), 128'(0));
    rd(1, v); chk("R1 setup", 128'(v), 128'(S));
  endtask

  task automatic t_basic();
    logic [2*NP-1:0] old;
    wr(0, 32'd2);
    wr(4, 32'h1 << 3);
    old = exp_state; set_exp(3, 2'd2);
    latch_timing("R3 pin3 pull-up", old);
    wr(5, 32'h1 << 8);
    old = exp_state; set_exp(40, 2'd2);
    latch_timing("R3 pin40 pull-up", old);
    wr(4, 0); wr(5, 0); wr(0, 0);
    repeat (S + 2) @(negedge clk);
    chk("R7 release keeps states", 128'(pull_state), 128'(exp_state));
    wr(0, 32'd1);
    repeat (S + 2) @(negedge clk);
    chk("R4 unselected pins hold", 128'(pull_state), 128'(exp_state));
    wr(0, 0);
  endtask

  task automatic t_reserved();
    logic [2*NP-1:0] old;
    wr(0, 32'd3);
    wr(4, 32'h1 << 3);
    old = exp_state; set_exp(3, 2'd0);
    latch_timing("R5 code3 folds to off", old);
    wr(4, 32'h1 << 7);
    wr(0, 32'd1);
    old = exp_state; set_exp(7, 2'd1);
    latch_timing("R5 code1 pull-down", old);
    wr(4, 0); wr(0, 0);
  endtask

  task automatic t_restart();
    logic [2*NP-1:0] old;
    wr(0, 32'd1);
    wr(4, 32'h1 << 10);
    @(negedge clk); @(negedge clk);
    wr(0, 32'd2);
    old = exp_state; set_exp(10, 2'd2);
    latch_timing("R6 code write restarts window", old);
    wr(4, 0); wr(0, 0);
  endtask

  task automatic t_bank_indep();
    logic [2*NP-1:0] old;
    wr(0, 32'd1);
    wr(4, 32'h1 << 12);
    wr(5, 32'h1);
    old = exp_state;
    repeat (S - 1) @(negedge clk);
    chk("R10 pin12 not yet", 128'(pull_state), 128'(old));
    @(negedge clk);
    set_exp(12, 2'd1);
    chk("R10 bank0 not restarted by bank1", 128'(pull_state), 128'(exp_state));
    @(negedge clk);
    set_exp(32, 2'd1);
    chk("R3 bank1 pin32 window", 128'(pull_state), 128'(exp_state));
    wr(4, 0); wr(5, 0); wr(0, 0);
  endtask

  task automatic t_setup0();
    wr(1, 32'd0);
    wr(0, 32'd2);
    wr(4, 32'h1 << 20);
    chk("R9 zero setup before edge", 128'(pull_state), 128'(exp_state));
    @(negedge clk);
    set_exp(20, 2'd2);
    chk("R9 zero setup capture", 128'(pull_state), 128'(exp_state));
    wr(4, 0); wr(0, 0); wr(1, S);
  endtask

  task automatic t_readback();
    rb_pin = 6'd40; @(negedge clk);
    chk("R8 readback pin40", 128'(rb_pull), 128'(2));
    rb_pin = 6'd12; @(negedge clk);
    chk("R8 readback pin12", 128'(rb_pull), 128'(1));
    rb_pin = 6'd60; @(negedge clk);
    chk("R8 readback out of range", 128'(rb_pull), 128'(0));
    rb_pin = 6'd0;
  endtask

  task automatic t_regs();
    logic [31:0] v;
    wr(0, 32'hFF);
    rd(0, v); chk("R2 code width", 128'(v), 128'(3));
    wr(5, 32'hFFFF_FFFF);
    rd(5, v); chk("R2 unimplemented mask bits", 128'(v), 128'(32'h003F_FFFF));
    wr(1, 32'h1FF);
    rd(1, v); chk("R2 setup width", 128'(v), 128'(32'hFF));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_basic();
    t_reserved();
    t_restart();
    t_bank_indep();
    t_setup0();
    t_readback();
    t_regs();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule